// File: doc/BRIEF.md
# Board Interrupt Aggregator

This block gathers up to sixteen level-sensitive interrupt requests coming from peripherals on a board and folds them into a single active-low request line that feeds one general-purpose input of the host processor. The processor detects the falling edge of that line. It then reads a pending register, combines it with the enable mask, and services the sources that are set.

Each source passes through a two-flip-flop synchroniser. While the synchronised source is high, its pending bit is set. The bit then stays set until software clears it by writing a zero to it. A clear write does not take effect while the source is still asserted, so a level request cannot be lost. An enable register decides which pending bits can pull the output low. The output is registered, so it does not glitch. Both registers sit in a small word-addressed window that has a plain address, write-strobe and data interface. Inputs that have no device attached are tied low and never show as pending.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the enable register (offset 0x00) and the pending register (offset 0x04) both read zero, and `n_irq_o` is high.
- R2: The enable register stores bits 15..0 of a write to offset 0x00 and returns them on a read. Bits 31..16 always read zero. Enable bits change only on a write to offset 0x00.
- R3: When source input i is held high, pending bit i is set within a few cycles, whatever the enable bit is. The pending bit stays set after the source returns low.
- R4: In a write to offset 0x04, a 1 leaves the corresponding pending bit unchanged and a 0 clears it when its source is inactive. A pending bit never rises unless its synchronised source was high.
- R5: A zero written to a pending bit while its source is still high leaves the bit set, because setting wins over clearing.
- R6: `n_irq_o` is low exactly when (pending AND enable) was nonzero on the previous clock edge, and high otherwise.
- R7: A source whose enable bit is 0 never pulls `n_irq_o` low, even while its pending bit is set.
- R8: Any address other than 0x00 and 0x04 reads zero, and a write to it changes neither register.
- R9: A source input held low, such as the unwired inputs 8 and 12, keeps its pending bit at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Level interrupt requests, active high, bit i = source i |
| addr_i | input | 20 | Byte address within the 1 MiB register window |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| n_irq_o | output | 1 | Combined interrupt request, active low |

## Verification
The hardest case to reach is a clear write that lands while the source is still high at the synchroniser output. The stimulus raises a source, waits until the pending bit has latched, and issues the clear with the source still held. Only then does it drop the source and clear again, and it repeats this for each of the sixteen sources. The output is also swept against every single-bit enable mask while a fixed pending pattern is present. That sweep shows that each source reaches the line only through its own enable bit.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int unsigned IRQ_NSRC   = 16;
    localparam int unsigned IRQ_ADDR_W = 20;
    localparam int unsigned IRQ_DATA_W = 32;
    localparam int unsigned OFS_ENABLE  = 'h00;
    localparam int unsigned OFS_PENDING = 'h04;

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_PENDING = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int unsigned NSRC   = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] async_i,
    output logic [NSRC-1:0] sync_o
);
    logic [NSRC-1:0] stage_d [STAGES];
    logic [NSRC-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int unsigned NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_sync_i,
    input  reg_sel_e        sel_i,
    input  logic            wr_en_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] enable_o,
    output logic [NSRC-1:0] pending_o
);
    typedef struct packed {
        logic [NSRC-1:0] enable;
        logic [NSRC-1:0] pending;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_enable, wr_pending;
    logic [NSRC-1:0] clear_mask;

    always_comb begin
        wr_enable  = wr_en_i && (sel_i == SEL_ENABLE);
        wr_pending = wr_en_i && (sel_i == SEL_PENDING);
        clear_mask = wr_pending ? ~wdata_i : '0;
        regs_d     = regs_q;
        if (wr_enable) regs_d.enable = wdata_i;
        // set dominates: an asserted level re-sets the bit the same cycle
        regs_d.pending = (regs_q.pending & ~clear_mask) | src_sync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign enable_o  = regs_q.enable;
    assign pending_o = regs_q.pending;

    // R2
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && sel_i == SEL_ENABLE) |=> $stable(regs_q.enable));

    // R3
    pending_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_sync_i) |=> ((regs_q.pending & $past(src_sync_i)) == $past(src_sync_i)));

    // R4
    pending_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((regs_q.pending & ~$past(regs_q.pending) & ~$past(src_sync_i)) == '0));

    // R8
    pending_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en_i && sel_i == SEL_PENDING) && src_sync_i == '0) |=> $stable(regs_q.pending));
endmodule

// File: rtl/irqagg_out.sv
module irqagg_out #(
    parameter int unsigned NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] enable_i,
    input  logic [NSRC-1:0] pending_i,
    output logic            n_irq_o
);
    logic [NSRC-1:0] masked;
    logic            n_irq_d, n_irq_q;

    always_comb begin
        masked  = pending_i & enable_i;
        n_irq_d = ~(|masked);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_irq_q <= 1'b1;
        else        n_irq_q <= n_irq_d;
    end

    assign n_irq_o = n_irq_q;

    // R6
    line_follows_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (n_irq_q == ~(|($past(pending_i) & $past(enable_i)))));

    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i == '0) |=> n_irq_q);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int unsigned NSRC        = IRQ_NSRC,
    parameter int unsigned ADDR_W      = IRQ_ADDR_W,
    parameter int unsigned DATA_W      = IRQ_DATA_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              n_irq_o
);
    logic [NSRC-1:0] src_sync;
    logic [NSRC-1:0] enable_q, pending_q;
    reg_sel_e        sel;

    always_comb begin
        if (addr_i == ADDR_W'(OFS_ENABLE))       sel = SEL_ENABLE;
        else if (addr_i == ADDR_W'(OFS_PENDING)) sel = SEL_PENDING;
        else                                     sel = SEL_NONE;
    end

    always_comb begin
        unique case (sel)
            SEL_ENABLE:  rdata_o = DATA_W'(enable_q);
            SEL_PENDING: rdata_o = DATA_W'(pending_q);
            default:     rdata_o = '0;
        endcase
    end

    if (NSRC < DATA_W) begin : g_hi
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^wdata_i[DATA_W-1:NSRC];
    end

    irqagg_sync #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    irqagg_regs #(.NSRC(NSRC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sync_i (src_sync),
        .sel_i      (sel),
        .wr_en_i    (wr_en_i),
        .wdata_i    (wdata_i[NSRC-1:0]),
        .enable_o   (enable_q),
        .pending_o  (pending_q)
    );

    irqagg_out #(.NSRC(NSRC)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable_q),
        .pending_i (pending_q),
        .n_irq_o   (n_irq_o)
    );
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src = '0;
    logic [19:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        n_irq;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
        .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .n_irq_o(n_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [19:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] pat;
        idle(3);
        rst_n = 1'b1;
        // R1
        rd(20'h0, v);  check("R1 enable", v, 32'h0);
        rd(20'h4, v);  check("R1 pending", v, 32'h0);
        check("R1 n_irq", {31'h0, n_irq}, 32'h1);

        // R2: each single bit plus junk in the top half
        for (int i = 0; i < 16; i++) begin
            wr(20'h0, 32'hFFFF_0000 | (32'h1 << i));
            rd(20'h0, v);
            check("R2 enable", v, 32'h1 << i);
        end
        wr(20'h0, 32'h1234_A5C3);
        rd(20'h0, v); check("R2 enable pattern", v, 32'h0000_A5C3);
        wr(20'h0, 32'h0);

        // R3 R4 R5 per source
        for (int i = 0; i < 16; i++) begin
            wr(20'h0, 32'h1 << i);
            src = 16'h1 << i;
            idle(5);
            rd(20'h4, v); check("R3 set", v, 32'h1 << i);
            check("R6 low", {31'h0, n_irq}, 32'h0);
            wr(20'h4, 32'h0);
            idle(2);
            rd(20'h4, v); check("R5 clear while held", v, 32'h1 << i);
            src = '0;
            idle(5);
            rd(20'h4, v); check("R3 latched", v, 32'h1 << i);
            wr(20'h4, 32'hFFFF_FFFF);
            idle(1);
            rd(20'h4, v); check("R4 write one keeps", v, 32'h1 << i);
            wr(20'h4, ~(32'h1 << i));
            rd(20'h4, v); check("R4 clear", v, 32'h0);
            idle(2);
            check("R6 high", {31'h0, n_irq}, 32'h1);
        end

        // R7: disabled source pending but line stays high
        wr(20'h0, 32'h0);
        src = 16'h0020;
        idle(5);
        src = '0;
        idle(4);
        rd(20'h4, v); check("R7 pending", v, 32'h0020);
        check("R7 n_irq masked", {31'h0, n_irq}, 32'h1);
        wr(20'h0, 32'h0020);
        idle(1);
        check("R6 after enable", {31'h0, n_irq}, 32'h0);
        wr(20'h4, 32'h0);

        // R9 and mask sweep: all wired sources pulse, 8 and 12 tied low
        src = 16'hEEFF;
        idle(5);
        src = '0;
        idle(4);
        rd(20'h4, v); check("R9 unwired stay zero", v, 32'h0000_EEFF);
        pat = 16'hEEFF;
        for (int i = 0; i < 16; i++) begin
            wr(20'h0, 32'h1 << i);
            idle(1);
            check("R6 R7 mask sweep", {31'h0, n_irq}, {31'h0, ~pat[i]});
        end

        // R8: other addresses
        wr(20'h0, 32'h0000_0F0F);
        wr(20'h8, 32'hFFFF_FFFF);
        wr(20'h10_0 , 32'h0);
        wr(20'hF_FFFC, 32'h0);
        rd(20'h8, v); check("R8 read other", v, 32'h0);
        rd(20'hF_FFFC, v); check("R8 read top", v, 32'h0);
        rd(20'h0, v); check("R8 enable kept", v, 32'h0000_0F0F);
        rd(20'h4, v); check("R8 pending kept", v, 32'h0000_EEFF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule